// File: doc/BRIEF.md
# Two-Stage Configuration Register Bank

This block holds a set of configuration words, each kept in two stages. The host and a bulk loader write the first stage. The second stage drives the functional logic of the chip through a flat vector of active values. Every update follows the same order: the first stage is written, and on a later edge the second stage copies it. The second stage therefore never holds a value that the first stage has not held.

An update-control word sits at the address just past the last configuration word. Its live bit picks one of two behaviours:
- Transparent: each host write also reaches the active output one edge later.
- Staged: host writes stay in the first stage until a commit copies every first stage to its second stage in the same edge.

A commit comes from a self-clearing bit in the control word or from the loader's transfer pulse. A third control bit enables page erase. Erase commands are passed on as a one-cycle request only while that bit is set.

Top module: `cfgbank_top`

## Requirements
- R1: After reset every first stage, every second stage and the control word are 0, so `cfg_active` and all reads return 0.
- R2: With control bit 0 clear, a host write to address a < DEPTH changes the read value of a on the next cycle and leaves `cfg_active` unchanged.
- R3: With control bit 0 set, a host write to word a appears in read-back after the write edge, and in slice a of `cfg_active` (bits a*W+W-1 down to a*W) after the following edge.
- R4: A host write with bit 1 set at address DEPTH makes every slice of `cfg_active` equal its first stage one edge later. Bit 1 always reads back as 0.
- R5: A loader write updates only the first stage, never the active output. If it targets a configuration address in the same cycle as a host write, the host configuration write is dropped. A `ld_xfer` pulse commits all words exactly as R4 does.
- R6: An `erase_cmd` sets `erase_req` high for exactly one cycle on the next cycle, with `erase_req_page` equal to the page given, only if control bit 2 was 1. Otherwise `erase_req` stays 0.
- R7: A read at address DEPTH returns bit 0 = live, bit 2 = erase enable, and all other bits 0.
- R8: Host writes above address DEPTH have no effect on any stage or on the control word, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Host address (configuration words 0..DEPTH-1, control at DEPTH) |
| host_wdata | input | W | Host write data |
| host_rdata | output | W | Read data for host_addr (combinational) |
| ld_we | input | 1 | Loader write strobe |
| ld_addr | input | AW | Loader address |
| ld_wdata | input | W | Loader write data |
| ld_xfer | input | 1 | Loader transfer pulse: commit all first stages |
| erase_cmd | input | 1 | Page erase command |
| erase_page | input | PAGE_W | Page to erase |
| erase_req | output | 1 | Erase request passed on to the memory |
| erase_req_page | output | PAGE_W | Page of the passed-on request |
| cfg_active | output | DEPTH*W | Second-stage values, word i in slice i |

## Verification
If a first stage is corrupted, the fault shows on `host_rdata` in the cycle after the write. If a second stage is corrupted, it shows on `cfg_active` no later than one edge after a commit or a transparent copy. A commit that leaks into staged mode shows as an early change of `cfg_active`, and so does a dropped write-ordering step. A commit bit that sticks shows as repeated copies of later staged edits. The bench compares every output in every cycle against a reference model, so each of these faults is caught in the cycle it first becomes visible.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
    localparam int CTL_LIVE_BIT     = 0;
    localparam int CTL_COMMIT_BIT   = 1;
    localparam int CTL_ERASE_EN_BIT = 2;

    typedef struct packed {
        logic live;
        logic erase_en;
        logic commit;
    } ctl_state_t;
endpackage

// File: rtl/cfgbank_stage.sv
module cfgbank_stage #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_a,
    input  logic [W-1:0] load_data,
    input  logic         copy_b,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_a) st_d.a = load_data;
        // second stage only ever takes what the first stage already held
        if (copy_b) st_d.b = st_q.a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_q = st_q.a;
    assign b_q = st_q.b;

    // R3 / R4: a copy delivers the previous first-stage value
    a_r3_copy_takes_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
        copy_b |=> (b_q == $past(a_q)));

    a_r2_no_copy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_b |=> $stable(b_q));
endmodule

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
    import cfgbank_pkg::*;
#(
    parameter int W      = 16,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [W-1:0]      ctl_wdata,
    input  logic              xfer,
    input  logic              erase_cmd,
    input  logic [PAGE_W-1:0] erase_page,
    output logic              live,
    output logic              commit_pulse,
    output logic [W-1:0]      ctl_rdata,
    output logic              erase_req,
    output logic [PAGE_W-1:0] erase_req_page
);
    typedef struct packed {
        ctl_state_t        ctl;
        logic              req;
        logic [PAGE_W-1:0] page;
    } ctrl_t;

    ctrl_t cs_d, cs_q;
    logic  trigger;

    assign trigger = (ctl_we && ctl_wdata[CTL_COMMIT_BIT]) || xfer;

    always_comb begin
        cs_d            = cs_q;
        cs_d.ctl.commit = trigger;
        if (ctl_we) begin
            cs_d.ctl.live     = ctl_wdata[CTL_LIVE_BIT];
            cs_d.ctl.erase_en = ctl_wdata[CTL_ERASE_EN_BIT];
        end
        cs_d.req  = erase_cmd && cs_q.ctl.erase_en;
        cs_d.page = erase_cmd ? erase_page : cs_q.page;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    always_comb begin
        ctl_rdata                   = '0;
        ctl_rdata[CTL_LIVE_BIT]     = cs_q.ctl.live;
        ctl_rdata[CTL_ERASE_EN_BIT] = cs_q.ctl.erase_en;
    end

    assign live           = cs_q.ctl.live;
    assign commit_pulse   = cs_q.ctl.commit;
    assign erase_req      = cs_q.req;
    assign erase_req_page = cs_q.page;

    // R6: requests only pass while erase is enabled
    a_r6_erase_gated: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(erase_cmd && cs_q.ctl.erase_en));

    // R4: the commit pulse lasts one cycle unless triggered again
    a_r4_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> (!commit_pulse || $past(trigger)));

    a_r7_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_COMMIT_BIT] == 1'b0);
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top #(
    parameter int DEPTH  = 8,
    parameter int W      = 16,
    parameter int PAGE_W = 6,
    localparam int AW    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [AW-1:0]        host_addr,
    input  logic [W-1:0]         host_wdata,
    output logic [W-1:0]         host_rdata,
    input  logic                 ld_we,
    input  logic [AW-1:0]        ld_addr,
    input  logic [W-1:0]         ld_wdata,
    input  logic                 ld_xfer,
    input  logic                 erase_cmd,
    input  logic [PAGE_W-1:0]    erase_page,
    output logic                 erase_req,
    output logic [PAGE_W-1:0]    erase_req_page,
    output logic [DEPTH*W-1:0]   cfg_active
);
    localparam logic [AW-1:0] CTL_ADDR = AW'(DEPTH);

    typedef struct packed {
        logic          pend;
        logic [AW-1:0] idx;
    } live_t;

    live_t lv_d, lv_q;

    logic          live, commit_pulse;
    logic [W-1:0]  ctl_rdata;
    logic          host_cfg, ld_cfg, host_acc, ctl_we;
    logic [W-1:0]  a_arr [DEPTH];
    logic [DEPTH*W-1:0] a_vec;

    assign host_cfg = host_we && (host_addr < CTL_ADDR);
    assign ld_cfg   = ld_we && (ld_addr < CTL_ADDR);
    assign host_acc = host_cfg && !ld_cfg;
    assign ctl_we   = host_we && (host_addr == CTL_ADDR);

    cfgbank_ctrl #(.W(W), .PAGE_W(PAGE_W)) ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_we         (ctl_we),
        .ctl_wdata      (host_wdata),
        .xfer           (ld_xfer),
        .erase_cmd      (erase_cmd),
        .erase_page     (erase_page),
        .live           (live),
        .commit_pulse   (commit_pulse),
        .ctl_rdata      (ctl_rdata),
        .erase_req      (erase_req),
        .erase_req_page (erase_req_page)
    );

    always_comb begin
        lv_d.pend = host_acc && live;
        lv_d.idx  = host_acc ? host_addr : lv_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lv_q <= '0;
        else        lv_q <= lv_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        logic         load_a;
        logic [W-1:0] load_data;
        logic         copy_b;
        logic [W-1:0] b_q;

        assign load_a    = (ld_cfg && ld_addr == AW'(i)) || (host_acc && host_addr == AW'(i));
        assign load_data = ld_cfg ? ld_wdata : host_wdata;
        assign copy_b    = commit_pulse || (lv_q.pend && lv_q.idx == AW'(i));

        cfgbank_stage #(.W(W)) stage_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_a    (load_a),
            .load_data (load_data),
            .copy_b    (copy_b),
            .a_q       (a_arr[i]),
            .b_q       (b_q)
        );

        assign cfg_active[i*W +: W] = b_q;
        assign a_vec[i*W +: W]      = a_arr[i];
    end

    always_comb begin
        host_rdata = '0;
        if (host_addr == CTL_ADDR) host_rdata = ctl_rdata;
        for (int i = 0; i < DEPTH; i++) begin
            if (host_addr == AW'(i)) host_rdata = a_arr[i];
        end
    end

    // R2: without a commit or a live copy the active vector holds
    a_r2_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit_pulse && !lv_q.pend) |=> $stable(cfg_active));

    // R4 / R5: a commit copies every first stage at once
    a_r4_commit_all: assert property (@(posedge clk) disable iff (!rst_n)
        commit_pulse |=> (cfg_active == $past(a_vec)));

    // R8: reads above the control word return zero
    a_r8_high_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr > CTL_ADDR) |-> (host_rdata == '0));
endmodule

// File: tb/cfgbank_top_tb_top.sv
module cfgbank_top_tb_top;
    localparam int DEPTH  = 8;
    localparam int W      = 16;
    localparam int PAGE_W = 6;
    localparam int AW     = $clog2(DEPTH + 1);

    logic clk = 0;
    logic rst_n = 0;
    logic host_we = 0;
    logic [AW-1:0] host_addr = '0;
    logic [W-1:0] host_wdata = '0;
    logic [W-1:0] host_rdata;
    logic ld_we = 0;
    logic [AW-1:0] ld_addr = '0;
    logic [W-1:0] ld_wdata = '0;
    logic ld_xfer = 0;
    logic erase_cmd = 0;
    logic [PAGE_W-1:0] erase_page = '0;
    logic erase_req;
    logic [PAGE_W-1:0] erase_req_page;
    logic [DEPTH*W-1:0] cfg_active;

    int checks = 0;
    int fails = 0;

    // reference model
    logic [W-1:0] mA [DEPTH];
    logic [W-1:0] mB [DEPTH];
    logic mLive = 0, mEen = 0, mCommit = 0, mPend = 0, mReq = 0;
    int   mIdx = 0;
    logic [PAGE_W-1:0] mPage = '0;

    always #5 clk = ~clk;

    cfgbank_top #(.DEPTH(DEPTH), .W(W), .PAGE_W(PAGE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata), .ld_xfer(ld_xfer),
        .erase_cmd(erase_cmd), .erase_page(erase_page),
        .erase_req(erase_req), .erase_req_page(erase_req_page),
        .cfg_active(cfg_active)
    );

    function automatic logic [W-1:0] exp_read(int a);
        logic [W-1:0] r = '0;
        if (a < DEPTH) r = mA[a];
        else if (a == DEPTH) begin
            r[0] = mLive;
            r[2] = mEen;
        end
        return r;
    endfunction

    function automatic logic [DEPTH*W-1:0] exp_active();
        logic [DEPTH*W-1:0] v;
        for (int i = 0; i < DEPTH; i++) v[i*W +: W] = mB[i];
        return v;
    endfunction

    task automatic check(string tag, logic [DEPTH*W-1:0] act, logic [DEPTH*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        host_we = 0; ld_we = 0; ld_xfer = 0; erase_cmd = 0;
    endtask

    // check outputs for the current state, then advance one edge and the model
    task automatic step(string tag);
        logic hcfg, lcfg;
        #1;
        check({tag, " active"}, cfg_active, exp_active());
        check({tag, " read"}, {{(DEPTH*W-W){1'b0}}, host_rdata},
              {{(DEPTH*W-W){1'b0}}, exp_read(int'(host_addr))});
        check("R6 erase", {{(DEPTH*W-PAGE_W-1){1'b0}}, erase_req, (erase_req ? erase_req_page : '0)},
              {{(DEPTH*W-PAGE_W-1){1'b0}}, mReq, (mReq ? mPage : '0)});
        @(posedge clk);
        for (int i = 0; i < DEPTH; i++)
            if (mCommit || (mPend && mIdx == i)) mB[i] = mA[i];
        hcfg = host_we && int'(host_addr) < DEPTH;
        lcfg = ld_we && int'(ld_addr) < DEPTH;
        mReq = erase_cmd && mEen;
        if (erase_cmd) mPage = erase_page;
        mCommit = (host_we && int'(host_addr) == DEPTH && host_wdata[1]) || ld_xfer;
        mPend = hcfg && !lcfg && mLive;
        if (hcfg && !lcfg) mIdx = int'(host_addr);
        if (lcfg) mA[int'(ld_addr)] = ld_wdata;
        else if (hcfg) mA[int'(host_addr)] = host_wdata;
        if (host_we && int'(host_addr) == DEPTH) begin
            mLive = host_wdata[0];
            mEen  = host_wdata[2];
        end
        @(negedge clk);
    endtask

    task automatic hwr(int a, logic [W-1:0] d);
        idle(); host_we = 1; host_addr = AW'(a); host_wdata = d;
    endtask

    task automatic hrd(int a);
        idle(); host_addr = AW'(a);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mA[i] = '0; mB[i] = '0; end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        hrd(0); step("R1");
        hrd(DEPTH); step("R1");
        // R2: staged write
        hwr(2, 16'hABCD); step("R2");
        hrd(2); step("R2");
        step("R2");
        // R4: commit
        hwr(DEPTH, 16'h0002); step("R4");
        hrd(DEPTH); step("R4");
        step("R4");
        // R3: transparent mode
        hwr(DEPTH, 16'h0001); step("R3");
        hwr(5, 16'h1234); step("R3");
        hrd(5); step("R3");
        step("R3");
        // R5: loader priority and transfer
        hwr(1, 16'h1111); ld_we = 1; ld_addr = AW'(1); ld_wdata = 16'h2222; step("R5");
        hrd(1); step("R5");
        idle(); ld_xfer = 1; step("R5");
        hrd(1); step("R5");
        // R6: erase gated off, then on
        idle(); erase_cmd = 1; erase_page = 6'd9; step("R6");
        idle(); step("R6");
        hwr(DEPTH, 16'h0004); step("R6");
        idle(); erase_cmd = 1; erase_page = 6'd5; step("R6");
        idle(); step("R6");
        // R7: control read-back after writing all ones
        hwr(DEPTH, 16'hFFFF); step("R7");
        hrd(DEPTH); step("R7");
        // R8: writes above the control word
        hwr(DEPTH + 3, 16'h5A5A); step("R8");
        hrd(DEPTH + 3); step("R8");
        hrd(DEPTH); step("R8");
        // random traffic
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom_range(0, 9);
            string tag;
            idle();
            host_addr  = AW'($urandom_range(0, (1 << AW) - 1));
            host_wdata = W'($urandom);
            tag = mLive ? "R3" : "R2";
            case (op)
                0, 1, 2: host_we = 1;
                3: begin host_we = 1; host_addr = AW'(DEPTH); tag = "R4"; end
                4, 5: begin
                    ld_we = 1; ld_addr = AW'($urandom_range(0, DEPTH - 1));
                    ld_wdata = W'($urandom); host_we = $urandom_range(0, 1); tag = "R5";
                end
                6: begin ld_xfer = 1; tag = "R5"; end
                7: begin
                    erase_cmd = 1; erase_page = PAGE_W'($urandom); tag = "R6";
                end
                default: tag = "R7";
            endcase
            if (int'(host_addr) > DEPTH) tag = "R8";
            step(tag);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule